// File: doc/BRIEF.md
# Saturating Doubling Multiply-Long Unit

This SIMD datapath takes two 128-bit source vectors holding signed elements. It multiplies them lane by lane, doubles each product and clamps the doubled value to a signed lane twice as wide as the source element. The clamped product can be written out as the result. It can also be added to the matching lane of a 128-bit destination input, or subtracted from it, and that second step saturates as well. Elements are either 16 bits wide, giving four 32-bit results, or 32 bits wide, giving two 64-bit results.

A half-select input chooses whether the lower or the upper 64 bits of each source feed the lanes. In by-element mode, one indexed element of the second source is broadcast to every lane in place of the vector operand. A sticky flag records that some lane has saturated since it was last cleared. Inputs are accepted on a valid strobe, and the result vector appears one clock later.

Top module: `sdml_unit`

## Requirements
- R1: With `wide`=0, result bits [32i+31:32i] (i=0..3) equal 2 × n × m saturated to signed 32 bits. n is the signed halfword i of `src_n`, or halfword i+4 when `upper`=1. m is taken from `src_m` in the same way.
- R2: With `wide`=1, result bits [64j+63:64j] (j=0..1) equal 2 × n × m saturated to signed 64 bits. n and m are the signed 32-bit words j (or j+2 when `upper`=1) of `src_n` and `src_m`.
- R3: The doubled product leaves the result range only when both elements are the most negative value (0x8000 or 0x80000000). That lane then gives the most positive value (0x7FFFFFFF or 0x7FFFFFFFFFFFFFFF) and counts as saturated.
- R4: `op` encoding: 0 writes the doubled product, 1 adds it to the `acc_in` lane, 2 subtracts it from the `acc_in` lane, and 3 behaves as 0.
- R5: The add and subtract steps clamp to the signed result-lane range and count as saturated when they clamp. For example, adding a positive product to 0x7FFFFFFF yields 0x7FFFFFFF, and subtracting one from 0x80000000 yields 0x80000000.
- R6: With `by_elem`=1, every lane's m is the element of `src_m` picked by `elem_idx`. In 16-bit mode the index counts halfwords 0..7 over all 128 bits. In 32-bit mode only `elem_idx[1:0]` is used and it counts words 0..3. `upper` does not affect m in this mode.
- R7: `out_valid` is high exactly one cycle after every cycle in which `in_valid` is high, and the new result appears in that same cycle.
- R8: While `in_valid` is low, `result` keeps its previous value, whatever the other inputs do.
- R9: `sat_flag` goes high one cycle after an accepted input in which any lane saturated. It stays high until a cycle with `sat_clr`=1 and no new saturation. If the clear and a new saturation fall in the same cycle, the flag stays high.
- R10: Synchronous reset clears `result`, `out_valid` and `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operands this cycle |
| op | input | 2 | 0 product, 1 add, 2 subtract, 3 product |
| wide | input | 1 | 0: 16-bit elements, 1: 32-bit elements |
| upper | input | 1 | Take the upper 64 bits of the sources |
| by_elem | input | 1 | Broadcast one indexed element of `src_m` |
| elem_idx | input | 3 | Element index for by-element mode |
| src_n | input | 128 | First source vector |
| src_m | input | 128 | Second source vector |
| acc_in | input | 128 | Destination lanes for add and subtract |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result updated this cycle |
| result | output | 128 | Registered result lanes |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The assertions check on every cycle the one-cycle valid timing, that the result holds while idle, that the flag stays set and clears as R9 describes, the reset state, the lane-0 most-negative squared case and the zero-operand case. The lane arithmetic, half selection, broadcast indexing and the saturating add and subtract depend on data, so only the bench's scenarios can show them. In those scenarios a behavioural model recomputes every lane with wide integers and compares the whole result vector and the flag after every clock.

// File: rtl/sdml_pkg.sv
package sdml_pkg;
  typedef enum logic [1:0] {
    OP_PROD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_RSV  = 2'd3
  } sdml_op_e;
endpackage

// File: rtl/sdml_operand_sel.sv
module sdml_operand_sel #(
  parameter int VEC_W = 128,
  parameter int EW    = 16,
  parameter int IDX_W = $clog2(VEC_W / EW)
) (
  input  logic [VEC_W-1:0]   src_n,
  input  logic [VEC_W-1:0]   src_m,
  input  logic               upper,
  input  logic               by_elem,
  input  logic [IDX_W-1:0]   idx,
  output logic [VEC_W/2-1:0] opa,
  output logic [VEC_W/2-1:0] opb
);
  localparam int HALF = VEC_W / 2;
  localparam int NL   = HALF / EW;

  logic [EW-1:0] bcast;

  always_comb begin
    bcast = src_m[int'(idx)*EW +: EW];
    opa   = upper ? src_n[VEC_W-1:HALF] : src_n[HALF-1:0];
    if (by_elem)
      opb = {NL{bcast}};
    else
      opb = upper ? src_m[VEC_W-1:HALF] : src_m[HALF-1:0];
  end
endmodule

// File: rtl/sdml_lane.sv
module sdml_lane #(
  parameter int EW = 16
) (
  input  logic signed [EW-1:0]   a,
  input  logic signed [EW-1:0]   b,
  input  logic signed [2*EW-1:0] acc,
  input  sdml_pkg::sdml_op_e     op,
  output logic [2*EW-1:0]        res,
  output logic                   sat
);
  import sdml_pkg::*;
  localparam int RW = 2 * EW;
  localparam logic signed [EW-1:0] EMIN = {1'b1, {(EW-1){1'b0}}};
  localparam logic signed [RW-1:0] RMAX = {1'b0, {(RW-1){1'b1}}};
  localparam logic signed [RW-1:0] RMIN = {1'b1, {(RW-1){1'b0}}};

  logic signed [RW-1:0] prod;
  logic signed [RW-1:0] dbl;
  logic                 dbl_ovf;
  logic signed [RW:0]   ext;
  logic                 ext_ovf;

  always_comb begin
    prod    = RW'(a) * RW'(b);
    dbl_ovf = (a == EMIN) && (b == EMIN);
    dbl     = dbl_ovf ? RMAX : (prod <<< 1);
    case (op)
      OP_ADD:  ext = {acc[RW-1], acc} + {dbl[RW-1], dbl};
      OP_SUB:  ext = {acc[RW-1], acc} - {dbl[RW-1], dbl};
      default: ext = {dbl[RW-1], dbl};
    endcase
    ext_ovf = ext[RW] != ext[RW-1];
    if (ext_ovf)
      res = ext[RW] ? RMIN : RMAX;
    else
      res = ext[RW-1:0];
    sat = dbl_ovf | ext_ovf;
  end
endmodule

// File: rtl/sdml_unit.sv
module sdml_unit #(
  parameter int VEC_W    = 128,
  parameter int NARROW_W = 16,
  parameter int IDX_W    = $clog2(VEC_W / NARROW_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic             wide,
  input  logic             upper,
  input  logic             by_elem,
  input  logic [IDX_W-1:0] elem_idx,
  input  logic [VEC_W-1:0] src_n,
  input  logic [VEC_W-1:0] src_m,
  input  logic [VEC_W-1:0] acc_in,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             sat_flag
);
  import sdml_pkg::*;

  localparam int WIDE_W  = 2 * NARROW_W;
  localparam int DWIDE_W = 2 * WIDE_W;
  localparam int HALF    = VEC_W / 2;
  localparam int NL_N    = HALF / NARROW_W;
  localparam int NL_W    = HALF / WIDE_W;
  localparam int WIDX_W  = $clog2(VEC_W / WIDE_W);

  sdml_op_e        op_e;
  logic [HALF-1:0] opa_n, opb_n, opa_w, opb_w;
  logic [VEC_W-1:0] res_n, res_w;
  logic [NL_N-1:0] sat_n;
  logic [NL_W-1:0] sat_w;
  logic            sat_now;

  assign op_e = sdml_op_e'(op);

  sdml_operand_sel #(.VEC_W(VEC_W), .EW(NARROW_W), .IDX_W(IDX_W)) u_sel_n (
    .src_n(src_n), .src_m(src_m), .upper(upper), .by_elem(by_elem),
    .idx(elem_idx), .opa(opa_n), .opb(opb_n)
  );

  sdml_operand_sel #(.VEC_W(VEC_W), .EW(WIDE_W), .IDX_W(WIDX_W)) u_sel_w (
    .src_n(src_n), .src_m(src_m), .upper(upper), .by_elem(by_elem),
    .idx(elem_idx[WIDX_W-1:0]), .opa(opa_w), .opb(opb_w)
  );

  for (genvar gi = 0; gi < NL_N; gi++) begin : g_nlane
    sdml_lane #(.EW(NARROW_W)) u_lane (
      .a  (opa_n[gi*NARROW_W +: NARROW_W]),
      .b  (opb_n[gi*NARROW_W +: NARROW_W]),
      .acc(acc_in[gi*WIDE_W +: WIDE_W]),
      .op (op_e),
      .res(res_n[gi*WIDE_W +: WIDE_W]),
      .sat(sat_n[gi])
    );
  end

  for (genvar gj = 0; gj < NL_W; gj++) begin : g_wlane
    sdml_lane #(.EW(WIDE_W)) u_lane (
      .a  (opa_w[gj*WIDE_W +: WIDE_W]),
      .b  (opb_w[gj*WIDE_W +: WIDE_W]),
      .acc(acc_in[gj*DWIDE_W +: DWIDE_W]),
      .op (op_e),
      .res(res_w[gj*DWIDE_W +: DWIDE_W]),
      .sat(sat_w[gj])
    );
  end

  assign sat_now = in_valid & (wide ? (|sat_w) : (|sat_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        result <= wide ? res_w : res_n;
      sat_flag <= (sat_flag & ~sat_clr) | sat_now;
    end
  end
endmodule

// File: rtl/sdml_unit_chk.sv
module sdml_unit_chk #(
  parameter int VEC_W    = 128,
  parameter int NARROW_W = 16,
  parameter int IDX_W    = $clog2(VEC_W / NARROW_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       op,
  input logic             wide,
  input logic             upper,
  input logic             by_elem,
  input logic [VEC_W-1:0] src_n,
  input logic [VEC_W-1:0] src_m,
  input logic             sat_clr,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             sat_flag
);
  localparam int WW = 2 * NARROW_W;
  localparam logic [NARROW_W-1:0] NMIN = {1'b1, {(NARROW_W-1){1'b0}}};
  localparam logic [WW-1:0]       WMAX = {1'b0, {(WW-1){1'b1}}};

  logic lane0_plain;
  assign lane0_plain = in_valid && (op == 2'd0) && !wide && !by_elem && !upper;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R7
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !sat_clr) |=> sat_flag); // R9
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (sat_clr && !in_valid) |=> !sat_flag); // R9
  AST_MINMIN_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (lane0_plain && src_n[NARROW_W-1:0] == NMIN && src_m[NARROW_W-1:0] == NMIN)
      |=> (result[WW-1:0] == WMAX && sat_flag)); // R3
  AST_ZERO_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    (lane0_plain && src_n[NARROW_W-1:0] == '0) |=> (result[WW-1:0] == '0)); // R1
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!out_valid && !sat_flag && result == '0)); // R10
endmodule

bind sdml_unit sdml_unit_chk #(.VEC_W(VEC_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .wide(wide), .upper(upper),
  .by_elem(by_elem), .src_n(src_n), .src_m(src_m), .sat_clr(sat_clr),
  .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
);

// File: tb/sdml_unit_test.sv
module sdml_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   op = 2'd0;
  logic         wide = 1'b0;
  logic         upper = 1'b0;
  logic         by_elem = 1'b0;
  logic [2:0]   elem_idx = 3'd0;
  logic [127:0] src_n = '0;
  logic [127:0] src_m = '0;
  logic [127:0] acc_in = '0;
  logic         sat_clr = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         sat_flag;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R10";
  bit    started = 0;
  bit    finished = 0;

  logic [127:0] e_res = '0;
  bit           e_val = 0;
  bit           e_sat = 0;
  bit           m_any;

  always #4 clk = ~clk;

  sdml_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .wide(wide), .upper(upper),
    .by_elem(by_elem), .elem_idx(elem_idx), .src_n(src_n), .src_m(src_m),
    .acc_in(acc_in), .sat_clr(sat_clr), .out_valid(out_valid), .result(result),
    .sat_flag(sat_flag)
  );

  function automatic logic signed [131:0] clampv(input logic signed [131:0] v, input int rw,
                                                  inout bit s);
    logic signed [131:0] mx;
    logic signed [131:0] mn;
    mx = (132'sd1 <<< (rw - 1)) - 132'sd1;
    mn = -(132'sd1 <<< (rw - 1));
    if (v > mx) begin s = 1; return mx; end
    if (v < mn) begin s = 1; return mn; end
    return v;
  endfunction

  function automatic logic [63:0] ref_lane(input longint a, input longint b, input longint acc,
                                           input int rw, input int opc, inout bit s);
    logic signed [131:0] p;
    p = 132'(a) * 132'(b) * 132'sd2;
    p = clampv(p, rw, s);
    if (opc == 1) p = clampv(132'(acc) + p, rw, s);
    else if (opc == 2) p = clampv(132'(acc) - p, rw, s);
    return p[63:0];
  endfunction

  function automatic logic [127:0] ref_vec(output bit any);
    logic [127:0] r;
    logic [63:0]  t;
    logic [15:0]  h;
    logic [31:0]  w;
    longint a, b, c;
    any = 0;
    r = '0;
    if (!wide) begin
      for (int i = 0; i < 4; i++) begin
        h = src_n[(i + 4 * int'(upper)) * 16 +: 16];
        a = $signed(h);
        h = by_elem ? src_m[int'(elem_idx) * 16 +: 16] : src_m[(i + 4 * int'(upper)) * 16 +: 16];
        b = $signed(h);
        w = acc_in[i * 32 +: 32];
        c = $signed(w);
        t = ref_lane(a, b, c, 32, int'(op), any);
        r[i * 32 +: 32] = t[31:0];
      end
    end else begin
      for (int j = 0; j < 2; j++) begin
        w = src_n[(j + 2 * int'(upper)) * 32 +: 32];
        a = $signed(w);
        w = by_elem ? src_m[int'(elem_idx[1:0]) * 32 +: 32] : src_m[(j + 2 * int'(upper)) * 32 +: 32];
        b = $signed(w);
        c = $signed(acc_in[j * 64 +: 64]);
        t = ref_lane(a, b, c, 64, int'(op), any);
        r[j * 64 +: 64] = t;
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_res = '0; e_val = 0; e_sat = 0;
    end else begin
      m_any = 0;
      e_val = in_valid;
      if (in_valid) e_res = ref_vec(m_any);
      e_sat = (e_sat & !sat_clr) | m_any;
    end
    started = 1;
    #2;
    if (started && !finished) begin
      checks++;
      if (result !== e_res) begin
        failures++;
        $display("FAIL %s result act=%h exp=%h", cur_req, result, e_res);
      end
      checks++;
      if (out_valid !== e_val) begin
        failures++;
        $display("FAIL %s out_valid act=%0b exp=%0b", cur_req, out_valid, e_val);
      end
      checks++;
      if (sat_flag !== e_sat) begin
        failures++;
        $display("FAIL %s sat_flag act=%0b exp=%0b", cur_req, sat_flag, e_sat);
      end
    end
  end

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic issue(input logic [1:0] o, input bit wd, input bit up, input bit be,
                       input logic [2:0] ix, input logic [127:0] n, input logic [127:0] m,
                       input logic [127:0] ac, input bit clr);
    @(negedge clk);
    in_valid = 1; op = o; wide = wd; upper = up; by_elem = be; elem_idx = ix;
    src_n = n; src_m = m; acc_in = ac; sat_clr = clr;
  endtask

  task automatic idle(input bit clr);
    @(negedge clk);
    in_valid = 0; op = 2'($urandom); wide = 1'($urandom); upper = 1'($urandom);
    by_elem = 1'($urandom); elem_idx = 3'($urandom);
    src_n = rnd128(); src_m = rnd128(); acc_in = rnd128(); sat_clr = clr;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    cur_req = "R10";
    repeat (3) @(negedge clk);
    rst = 0;
    idle(0);

    cur_req = "R1";
    issue(2'd0, 0, 0, 0, 0, '0, rnd128(), '0, 0);
    for (int k = 0; k < 40; k++) issue(2'd0, 0, 1'(k), 0, 0, rnd128(), rnd128(), rnd128(), 0);
    issue(2'd0, 0, 0, 0, 0, {8{16'h0003}}, {8{16'hFFFE}}, '0, 0);

    cur_req = "R2";
    for (int k = 0; k < 40; k++) issue(2'd0, 1, 1'(k), 0, 0, rnd128(), rnd128(), rnd128(), 0);
    issue(2'd0, 1, 1, 0, 0, {4{32'h7FFFFFFF}}, {4{32'h7FFFFFFF}}, '0, 0);

    cur_req = "R3";
    idle(1);
    issue(2'd0, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, '0, 0);
    idle(1);
    issue(2'd0, 1, 1, 0, 0, {4{32'h80000000}}, {4{32'h80000000}}, '0, 0);
    idle(1);
    issue(2'd0, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8001}}, '0, 0);
    idle(0);

    cur_req = "R4";
    for (int k = 0; k < 40; k++) issue(2'(k), 1'(k >> 2), 1'(k >> 3), 0, 0, rnd128(), rnd128(), rnd128(), 1);

    cur_req = "R5";
    idle(1);
    issue(2'd1, 0, 0, 0, 0, {8{16'h0001}}, {8{16'h0001}}, {4{32'h7FFFFFFF}}, 0);
    idle(1);
    issue(2'd2, 0, 0, 0, 0, {8{16'h0001}}, {8{16'h0001}}, {4{32'h80000000}}, 0);
    idle(1);
    issue(2'd1, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, {4{32'h7FFFFFFF}}, 0);
    idle(1);
    issue(2'd2, 1, 0, 0, 0, {4{32'h00000001}}, {4{32'h00000001}}, {2{64'h8000000000000000}}, 0);
    idle(1);
    issue(2'd1, 1, 1, 0, 0, {4{32'h80000000}}, {4{32'h80000000}}, {2{64'h7FFFFFFFFFFFFFFF}}, 0);
    idle(1);
    issue(2'd2, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, {4{32'h00000000}}, 0);
    idle(1);
    issue(2'd1, 0, 0, 0, 0, {8{16'h0001}}, {8{16'h0001}}, {4{32'h7FFFFFFD}}, 0);
    idle(1);

    cur_req = "R6";
    for (int k = 0; k < 32; k++) issue(2'($urandom_range(0, 2)), 1'(k >> 3), 1'(k), 1, 3'(k),
                                       rnd128(), rnd128(), rnd128(), 1);

    cur_req = "R7";
    for (int k = 0; k < 12; k++) begin
      if (k % 3 == 0) idle(0);
      else issue(2'd0, 0, 0, 0, 0, rnd128(), rnd128(), '0, 0);
    end

    cur_req = "R8";
    issue(2'd0, 0, 0, 0, 0, rnd128(), rnd128(), '0, 0);
    for (int k = 0; k < 10; k++) idle(0);

    cur_req = "R9";
    idle(1);
    issue(2'd0, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, '0, 0);
    issue(2'd0, 0, 0, 0, 0, {8{16'h0002}}, {8{16'h0002}}, '0, 0);
    idle(0);
    idle(0);
    idle(1);
    idle(0);
    issue(2'd0, 1, 0, 0, 0, {4{32'h80000000}}, {4{32'h80000000}}, '0, 1);
    idle(0);
    idle(1);
    issue(2'd0, 0, 0, 0, 0, {8{16'h0002}}, {8{16'h0002}}, '0, 1);

    cur_req = "R10";
    @(negedge clk);
    rst = 1;
    in_valid = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    in_valid = 0;
    idle(0);
    idle(0);
    @(negedge clk);
    finish_run();
  end
endmodule